// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Gray Intermediate

This block is the digital back end of a 6-bit flash converter. A bank of 63 comparators gives a thermometer word: the number of asserted bits is the sampled level. A front stage first cleans up single-bit glitches in that word. It replaces every bit with the 2-of-3 majority of the bit and its two neighbours. The cleaned word then goes through window logic that produces a reflected-binary Gray code. Each Gray bit is an OR of "level at least a, and not at least b" terms. A ripple XOR chain, which starts at the most significant bit, turns the Gray code into the binary level.

A separate flag reports that the raw comparator word was not monotonic. It does so even when the majority stage has repaired the word. The flag lets the system count or discard suspect samples. A parameter chooses one of two variants. In the first, the outputs follow the input combinationally. In the second, the outputs are captured on a rising clock edge when a valid strobe is high, and an active-low synchronous reset clears them.

Top module: `therm_gray_encoder`

## Requirements
- R1: Input bit `therm_in[i]` is comparator i+1, the comparator that asserts (i+1)-th as the signal rises. For a monotonic word with L low-order ones (L = 0..63), `bin_out` equals L.
- R2: `gray_out` is the reflected-binary code of the cleaned level, gray = L XOR (L >> 1). For example, level 1 gives 000001, level 2 gives 000011, level 3 gives 000010, level 32 gives 110000 and level 63 gives 100000.
- R3: The binary word is formed from the Gray word MSB first: b5 = g5, and each lower b[i] = b[i+1] XOR g[i]. So `bin_out` XOR (`bin_out` >> 1) always equals `gray_out`.
- R4: Consider a monotonic level-L word with one bit flipped. The flipped bit is a 0 at index p <= L-3, or a 1 at index p >= L+2. This word is encoded exactly as level L. The missing neighbour below index 0 counts as 1, and the missing neighbour above index 62 counts as 0.
- R5: A single flipped bit right next to the edge is resolved to the adjacent level. A 0 at index L-2 gives level L-1, and a 1 at index L+1 gives level L+1.
- R6: `bad_code` is 1 exactly when the raw word has some index i with `therm_in[i]` = 1 and `therm_in[i-1]` = 0. For monotonic words it is 0, and this includes words that differ from a level only at index L-1 or L.
- R7: With REG_OUT = 1, a rising edge with `rst_n` high and `vld_in` high loads all three outputs from the current input. The outputs show the result one cycle after the input is presented.
- R8: With REG_OUT = 1, a rising edge with `vld_in` low leaves all three outputs unchanged, whatever the input is.
- R9: With REG_OUT = 1, a rising edge with `rst_n` low clears `gray_out`, `bin_out` and `bad_code` to 0, even when `vld_in` is high.
- R10: With REG_OUT = 0, the outputs follow the input with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the registered variant |
| rst_n | input | 1 | Synchronous active-low clear of the output registers |
| vld_in | input | 1 | Capture strobe for the registered variant |
| therm_in | input | 63 | Raw comparator word; bit 0 is the lowest threshold |
| gray_out | output | 6 | Gray code of the cleaned level |
| bin_out | output | 6 | Binary level |
| bad_code | output | 1 | Raw word was not monotonic |

## Verification
The bench sweeps every level, both on its own and with every possible single-bit flip. This catches four kinds of fault:
- an off-by-one window bound, which puts one Gray bit wrong at a power-of-two boundary;
- a wrong boundary neighbour in the majority stage, which breaks levels 0 and 63 or flips at index 0 and 62;
- a filter that uses already-filtered neighbours, which would shift the result of flips near the edge;
- a flag computed from the cleaned word, which would stay low on repaired bubbles.

The register variant is checked for three faults: capture while the strobe is low, a reset that loses to the strobe, and a missing one-cycle latency. The combinational variant is checked for outputs that do not follow the input within the same cycle.

// File: rtl/tge_pkg.sv
// Shared helpers for the thermometer encoder.
// Assumes nothing beyond plain 1-bit logic values.
package tge_pkg;

    // 2-of-3 vote used by the bubble filter
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tge_bubble_filter.sv
// Replaces each thermometer bit with the majority of itself and its raw
// neighbours. The virtual bit below index 0 is 1, the one above the top is 0.
// Assumes: isolated glitches only; wider bursts are passed through partly.
module tge_bubble_filter #(
    parameter int unsigned WIDTH = 63
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] clean_o
);
    import tge_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic below, above;
        // neighbour below, tied to 1 at the bottom end
        if (i == 0) begin : g_lo_edge
            assign below = 1'b1;
        end else begin : g_lo_mid
            assign below = raw_i[i-1];
        end
        // neighbour above, tied to 0 at the top end
        if (i == WIDTH - 1) begin : g_hi_edge
            assign above = 1'b0;
        end else begin : g_hi_mid
            assign above = raw_i[i+1];
        end
        // vote
        assign clean_o[i] = maj3(below, raw_i[i], above);
    end
endmodule

// File: rtl/tge_gray_windows.sv
// Builds the reflected-binary Gray code from a thermometer word. Gray bit k
// is 1 for levels in windows [a, a + 2^(k+1)), where a = 2^k + m*2^(k+2).
// Each window is "level >= a AND NOT level >= b".
// Assumes: bit j of the word means "level >= j+1".
module tge_gray_windows #(
    parameter int unsigned BITS = 6,
    localparam int unsigned LEVELS = 1 << BITS,
    localparam int unsigned WIDTH  = LEVELS - 1
) (
    input  logic [WIDTH-1:0] clean_i,
    output logic [BITS-1:0]  gray_o
);
    // ext[j] = level >= j; ext[0] always true, ext[LEVELS] always false
    logic [LEVELS:0] ext;
    assign ext = {1'b0, clean_i, 1'b1};

    for (genvar k = 0; k < BITS; k++) begin : g_bit
        localparam int NWIN = (LEVELS >> (k + 2)) + 1;
        logic [NWIN-1:0] hit;
        for (genvar m = 0; m < NWIN; m++) begin : g_win
            localparam int LO     = (1 << k) + m * (1 << (k + 2));
            localparam int HI_RAW = LO + (1 << (k + 1));
            localparam int HI     = (HI_RAW > LEVELS) ? LEVELS : HI_RAW;
            if (LO < LEVELS) begin : g_on
                // one window term
                assign hit[m] = ext[LO] & ~ext[HI];
            end else begin : g_off
                assign hit[m] = 1'b0;
            end
        end
        // any window of this bit
        assign gray_o[k] = |hit;
    end
endmodule

// File: rtl/tge_gray_to_bin.sv
// Ripple XOR chain from the MSB down: each binary bit is the binary bit
// above it XOR the Gray bit at its own position.
// Assumes: BITS >= 2.
module tge_gray_to_bin #(
    parameter int unsigned BITS = 6
) (
    input  logic [BITS-1:0] gray_i,
    output logic [BITS-1:0] bin_o
);
    // running XOR, MSB first
    always_comb begin
        logic acc;
        acc = gray_i[BITS-1];
        bin_o[BITS-1] = acc;
        for (int i = int'(BITS) - 2; i >= 0; i--) begin
            acc = acc ^ gray_i[i];
            bin_o[i] = acc;
        end
    end
endmodule

// File: rtl/therm_gray_encoder.sv
// Top of the flash back-end encoder: majority bubble filter, Gray window
// logic, Gray-to-binary chain and a monotonicity flag on the raw word.
// REG_OUT selects registered outputs (strobe capture, synchronous
// active-low clear) or purely combinational outputs.
// Assumes: the raw word is held stable around the capturing edge.
module therm_gray_encoder #(
    parameter int unsigned BITS    = 6,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned WIDTH  = (1 << BITS) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_in,
    input  logic [WIDTH-1:0] therm_in,
    output logic [BITS-1:0]  gray_out,
    output logic [BITS-1:0]  bin_out,
    output logic             bad_code
);
    logic [WIDTH-1:0] clean_c;
    logic [BITS-1:0]  gray_c;
    logic [BITS-1:0]  bin_c;
    logic             bad_c;

    tge_bubble_filter #(.WIDTH(WIDTH)) u_filt (
        .raw_i   (therm_in),
        .clean_o (clean_c)
    );

    tge_gray_windows #(.BITS(BITS)) u_gray (
        .clean_i (clean_c),
        .gray_o  (gray_c)
    );

    tge_gray_to_bin #(.BITS(BITS)) u_g2b (
        .gray_i (gray_c),
        .bin_o  (bin_c)
    );

    // flag any 1 sitting above a 0 in the raw word
    assign bad_c = |(therm_in[WIDTH-1:1] & ~therm_in[WIDTH-2:0]);

    // a monotonic raw word must leave the filter untouched
    assert_clean_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_c |-> (clean_c == therm_in));

    // window logic and XOR chain must agree on the Gray relation
    assert_gray_bin_rel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gray_c == (bin_c ^ (bin_c >> 1)));

    if (REG_OUT) begin : g_reg
        // capture on strobe, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gray_out <= '0;
                bin_out  <= '0;
                bad_code <= 1'b0;
            end else if (vld_in) begin
                gray_out <= gray_c;
                bin_out  <= bin_c;
                bad_code <= bad_c;
            end
        end

        assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
            vld_in |=> (bin_out == $past(bin_c)) && (bad_code == $past(bad_c)));

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_in |=> $stable(bin_out) && $stable(gray_out) && $stable(bad_code));
    end else begin : g_comb
        assign gray_out = gray_c;
        assign bin_out  = bin_c;
        assign bad_code = bad_c;
    end
endmodule

// File: tb/sim_therm_gray_encoder.sv
// Sweeps every level with and without every single-bit flip on a registered
// instance (u0) and a combinational instance (u1); checks hold and reset.
module sim_therm_gray_encoder;
    localparam int BITS   = 6;
    localparam int LEVELS = 1 << BITS;
    localparam int WIDTH  = LEVELS - 1;
    localparam time CLK_P = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vld_in = 1'b0;
    logic [WIDTH-1:0] therm_in = '0;
    logic [BITS-1:0]  gray0, bin0, gray1, bin1;
    logic             bad0, bad1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    therm_gray_encoder #(.BITS(BITS), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .therm_in(therm_in),
        .gray_out(gray0), .bin_out(bin0), .bad_code(bad0));

    therm_gray_encoder #(.BITS(BITS), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .therm_in(therm_in),
        .gray_out(gray1), .bin_out(bin1), .bad_code(bad1));

    function automatic logic [WIDTH-1:0] level_word(input int lvl);
        logic [LEVELS-1:0] w;
        w = (LEVELS'(1) << lvl) - LEVELS'(1);
        return w[WIDTH-1:0];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge, sample a quarter period later
    task automatic present(input logic [WIDTH-1:0] w, input logic v);
        @(negedge clk);
        therm_in = w;
        vld_in   = v;
        @(posedge clk);
        #(CLK_P/4);
    endtask

    initial begin
        int exp_lvl;
        int exp_bad;
        string tag;

        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk("R9 reset bin", int'(bin0), 0);
        chk("R9 reset gray", int'(gray0), 0);
        chk("R9 reset bad", int'(bad0), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            for (int p = -1; p < WIDTH; p++) begin
                logic [WIDTH-1:0] w;
                w = level_word(lvl);
                if (p >= 0) w[p] = ~w[p];
                if (p < 0) begin
                    exp_lvl = lvl; exp_bad = 0; tag = "R1";
                end else if (p == lvl - 1) begin
                    exp_lvl = lvl - 1; exp_bad = 0; tag = "R6";
                end else if (p == lvl) begin
                    exp_lvl = lvl + 1; exp_bad = 0; tag = "R6";
                end else if (p == lvl - 2) begin
                    exp_lvl = lvl - 1; exp_bad = 1; tag = "R5";
                end else if (p == lvl + 1) begin
                    exp_lvl = lvl + 1; exp_bad = 1; tag = "R5";
                end else begin
                    exp_lvl = lvl; exp_bad = 1; tag = "R4";
                end
                present(w, 1'b1);
                chk({tag, " R7 bin reg"}, int'(bin0), exp_lvl);
                chk("R2 gray reg", int'(gray0), exp_lvl ^ (exp_lvl >> 1));
                chk("R6 bad reg", int'(bad0), exp_bad);
                chk({tag, " R10 bin comb"}, int'(bin1), exp_lvl);
                chk("R3 gray comb", int'(gray1), exp_lvl ^ (exp_lvl >> 1));
                chk("R6 bad comb", int'(bad1), exp_bad);
            end
        end

        // hold while strobe is low
        present(level_word(10), 1'b1);
        chk("R7 load 10", int'(bin0), 10);
        present(level_word(50) ^ 63'h4, 1'b0);
        chk("R8 hold bin", int'(bin0), 10);
        chk("R8 hold gray", int'(gray0), 10 ^ 5);
        chk("R8 hold bad", int'(bad0), 0);
        chk("R10 comb follows", int'(bin1), 50);
        present(level_word(33), 1'b0);
        chk("R8 hold again", int'(bin0), 10);

        // reset wins over strobe
        @(negedge clk);
        rst_n = 1'b0;
        present(level_word(40) ^ 63'h1, 1'b1);
        chk("R9 sync clear bin", int'(bin0), 0);
        chk("R9 sync clear gray", int'(gray0), 0);
        chk("R9 sync clear bad", int'(bad0), 0);
        @(negedge clk);
        rst_n = 1'b1;
        present(level_word(63), 1'b1);
        chk("R1 top level", int'(bin0), 63);
        chk("R2 top gray", int'(gray0), 32);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule